// File: doc/BRIEF.md
# MII PTP Event Timestamp Unit

This block listens, without driving anything, to the receive and transmit nibble streams of a media-independent interface (MII) between an Ethernet PHY and a MAC. For every frame it finds the start-of-frame delimiter and records the local time at that point. It then parses the frame header to decide whether the frame carries a PTP event message. Two carriers are accepted: a raw Ethernet frame with the PTP EtherType, and an IPv4 datagram with UDP addressed to the event port. When the frame qualifies, the recorded time becomes a timestamp. It is stored together with the message type and sequence number in a per-direction slot, and the interrupt is raised.

The time base is a seconds counter and a nanoseconds counter. On each tick the nanoseconds advance by a nominal step of 20, the period of a 50 MHz reference. The host can add a small signed trim to that step. It can also load an absolute time through the same register port it uses to read the timestamps. Each direction has an activity pulse for driving an indicator.

Top module: `ptp_mii_tsu`

## Requirements
- R1: On each MII side, a frame starts when one or more nibbles of 0x5 are followed by a nibble 0xD while the valid input is high. The captured timestamp is the counter value present in the cycle in which the first nibble after the 0xD is presented. Bytes arrive low nibble first and are numbered from 0 at that nibble.
- R2: No timestamp is stored for any frame that fails a check below. This includes a frame whose valid input drops before byte 31 of the PTP header has been received.
- R3: A frame whose bytes 12..13 equal 0x88F7 carries PTP directly, with the PTP header starting at byte 14.
- R4: A frame qualifies as UDP/IPv4 event PTP only when all of the following hold: bytes 12..13 are 0x0800, byte 14 is 0x45, byte 23 is 17, and bytes 36..37 are 0x013F (port 319). In that case the PTP header starts at byte 42, 28 bytes later than in R3.
- R5: Only event messages are stamped. The messageType is the low nibble of PTP header byte 0, and values 8..15 are ignored. The sequence number is header bytes 30 (high) and 31 (low).
- R6: On every clock the nanoseconds advance by 20 plus the trim. When they reach 1,000,000,000 they wrap, and the seconds count up by one.
- R7: Writing address 1 stages a seconds value. Writing address 2 loads the staged seconds together with the written nanoseconds; a nanoseconds value of 1e9 or more loads 0. The counter shows the loaded value in the cycle after the write.
- R8: Address 3 holds a signed trim in the range -8..7, read back sign-extended to 32 bits. A write whose value lies outside that range is ignored.
- R9: The receive slot is at addresses 8..10 and the transmit slot at 12..14: seconds, then nanoseconds, then an info word with messageType in bits 19:16 and sequence in bits 15:0. Read data appears one cycle after the read strobe. Reading the info word empties that slot.
- R10: Status at address 0 holds receive full in bit 0, receive overflow in bit 1, transmit full in bit 2 and transmit overflow in bit 3. A new stamp arriving at a full slot sets overflow and replaces the held stamp.
- R11: The interrupt output is high exactly while either slot is full.
- R12: Each stored stamp gives a one-cycle pulse on that direction's activity output.
- R13: The two directions are stamped independently, and frames on both sides at the same time are both stamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one time-base tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive nibble valid |
| rx_d | input | 4 | Receive nibble |
| tx_en | input | 1 | Transmit nibble valid |
| tx_d | input | 4 | Transmit nibble |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 4 | Register word address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, valid one cycle after the read strobe |
| irq | output | 1 | Timestamp available |
| rx_act | output | 1 | Receive PTP event activity pulse |
| tx_act | output | 1 | Transmit PTP event activity pulse |

## Verification
The bench checks the time of the first nibble after the delimiter, including stamps that fall across a nanosecond rollover and stamps taken with a negative trim. A design that latched one nibble late or early would be off by one step, and a wrong wrap would show a bad nanosecond or seconds field. Negative frames are sent that fail exactly one qualifying check each: wrong EtherType, wrong UDP port, wrong IP protocol, a general message type, or a frame cut short before the last sequence byte. A parser that checked too little would stamp them. Two frames sent back to back on one side, and frames sent on both sides at once, test that overflow keeps the newer stamp and that the slots do not interfere.

// File: rtl/ptp_tsu_pkg.sv
package ptp_tsu_pkg;

    localparam int SEC_W       = 32;
    localparam int NS_W        = 30;
    localparam int NS_PER_SEC  = 1_000_000_000;
    localparam int BIDX_W      = 7;

    localparam logic [15:0] ETYPE_PTP   = 16'h88F7;
    localparam logic [15:0] ETYPE_IPV4  = 16'h0800;
    localparam logic [7:0]  IPV4_VIHL   = 8'h45;
    localparam logic [7:0]  IP_PROTO_UDP = 8'd17;
    localparam logic [15:0] UDP_EVT_PORT = 16'd319;

    localparam int OFS_ETYPE    = 12;
    localparam int OFS_IP       = 14;
    localparam int OFS_IP_PROTO = OFS_IP + 9;
    localparam int OFS_UDP_DST  = OFS_IP + 20 + 2;
    localparam int PTP_BASE_L2  = 14;
    localparam int PTP_BASE_L3  = PTP_BASE_L2 + 28;
    localparam int PTP_SEQ_OFS  = 30;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } ptp_time_t;

    typedef struct packed {
        ptp_time_t   ts;
        logic [3:0]  msg_type;
        logic [15:0] seq_id;
    } ptp_stamp_t;

    typedef enum logic [1:0] {ENC_NONE, ENC_L2, ENC_IP, ENC_UDP} ptp_enc_e;
    typedef enum logic [1:0] {PS_IDLE, PS_PRE, PS_BODY, PS_DROP} mii_state_e;

    function automatic logic [BIDX_W-1:0] ptp_base(ptp_enc_e e);
        return (e == ENC_UDP) ? BIDX_W'(PTP_BASE_L3) : BIDX_W'(PTP_BASE_L2);
    endfunction

    function automatic ptp_time_t time_add(ptp_time_t t, logic [NS_W-1:0] step);
        ptp_time_t r;
        logic [NS_W:0] sum;
        sum = {1'b0, t.ns} + {1'b0, step};
        if (sum >= (NS_W+1)'(NS_PER_SEC)) begin
            r.ns  = NS_W'(sum - (NS_W+1)'(NS_PER_SEC));
            r.sec = t.sec + 1'b1;
        end else begin
            r.ns  = sum[NS_W-1:0];
            r.sec = t.sec;
        end
        return r;
    endfunction

endpackage

// File: rtl/ptp_time_base.sv
module ptp_time_base
    import ptp_tsu_pkg::*;
#(
    parameter int TRIM_W  = 4,
    parameter int NS_STEP = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  ptp_time_t                load_val,
    input  logic signed [TRIM_W-1:0] trim,
    output ptp_time_t                now
);

    logic [NS_W-1:0] step;
    assign step = NS_W'(NS_STEP) + {{(NS_W-TRIM_W){trim[TRIM_W-1]}}, trim};

    always_ff @(posedge clk) begin
        if (rst)       now <= '0;
        else if (load) now <= load_val;
        else           now <= time_add(now, step);
    end

    AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        now.ns < NS_W'(NS_PER_SEC));                                     // R6
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        !load |=> (now.sec == $past(now.sec) ||
                   now.sec == SEC_W'($past(now.sec) + 1'b1)));           // R6
    AST_NS_MOVES: assert property (@(posedge clk) disable iff (rst)
        !load |=> now.ns != $past(now.ns));                              // R6
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> now == $past(load_val));                                // R7

endmodule

// File: rtl/mii_ptp_snoop.sv
module mii_ptp_snoop
    import ptp_tsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dv,
    input  logic [3:0] nib,
    input  ptp_time_t  now,
    output logic       stamp_vld,
    output ptp_stamp_t stamp
);

    mii_state_e         state;
    logic               first;
    logic               phase;
    logic [3:0]         lo_nib;
    logic [BIDX_W-1:0]  byte_idx;
    ptp_enc_e           enc;
    logic [7:0]         et_hi;
    logic [3:0]         msg_type;
    logic [7:0]         seq_hi;
    ptp_time_t          ts_hold;

    logic [7:0]         cur_byte;
    logic [BIDX_W-1:0]  rel;
    logic               enc_ptp;
    ptp_enc_e           enc_nx;
    logic               hit;

    assign cur_byte = {nib, lo_nib};
    assign enc_ptp  = (enc == ENC_L2) || (enc == ENC_UDP);
    assign rel      = byte_idx - ptp_base(enc);

    always_comb begin
        enc_nx = enc;
        hit    = 1'b0;
        if (byte_idx == BIDX_W'(OFS_ETYPE + 1)) begin
            if ({et_hi, cur_byte} == ETYPE_PTP)       enc_nx = ENC_L2;
            else if ({et_hi, cur_byte} == ETYPE_IPV4) enc_nx = ENC_IP;
            else                                      enc_nx = ENC_NONE;
        end else if (enc == ENC_IP) begin
            if (byte_idx == BIDX_W'(OFS_IP) && cur_byte != IPV4_VIHL)
                enc_nx = ENC_NONE;
            if (byte_idx == BIDX_W'(OFS_IP_PROTO) && cur_byte != IP_PROTO_UDP)
                enc_nx = ENC_NONE;
            if (byte_idx == BIDX_W'(OFS_UDP_DST) && cur_byte != UDP_EVT_PORT[15:8])
                enc_nx = ENC_NONE;
            if (byte_idx == BIDX_W'(OFS_UDP_DST + 1))
                enc_nx = (cur_byte == UDP_EVT_PORT[7:0]) ? ENC_UDP : ENC_NONE;
        end else if (enc_ptp) begin
            if (rel == '0 && cur_byte[3])
                enc_nx = ENC_NONE;
            if (rel == BIDX_W'(PTP_SEQ_OFS + 1))
                hit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        stamp_vld <= 1'b0;
        if (rst) begin
            state    <= PS_IDLE;
            first    <= 1'b0;
            phase    <= 1'b0;
            lo_nib   <= '0;
            byte_idx <= '0;
            enc      <= ENC_NONE;
            et_hi    <= '0;
            msg_type <= '0;
            seq_hi   <= '0;
            ts_hold  <= '0;
            stamp    <= '0;
        end else if (!dv) begin
            state <= PS_IDLE;
        end else begin
            unique case (state)
                PS_IDLE: state <= (nib == 4'h5) ? PS_PRE : PS_DROP;
                PS_PRE: begin
                    if (nib == 4'hD) begin
                        state    <= PS_BODY;
                        first    <= 1'b1;
                        phase    <= 1'b0;
                        byte_idx <= '0;
                        enc      <= ENC_NONE;
                    end else if (nib != 4'h5) begin
                        state <= PS_DROP;
                    end
                end
                PS_BODY: begin
                    if (first) begin
                        ts_hold <= now;
                        first   <= 1'b0;
                    end
                    phase <= ~phase;
                    if (!phase) begin
                        lo_nib <= nib;
                    end else begin
                        if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
                        enc <= enc_nx;
                        if (byte_idx == BIDX_W'(OFS_ETYPE)) et_hi <= cur_byte;
                        if (enc_ptp && rel == '0) msg_type <= cur_byte[3:0];
                        if (enc_ptp && rel == BIDX_W'(PTP_SEQ_OFS)) seq_hi <= cur_byte;
                        if (hit) begin
                            stamp_vld <= 1'b1;
                            stamp     <= '{ts: ts_hold, msg_type: msg_type,
                                           seq_id: {seq_hi, cur_byte}};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_STAMP_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        stamp_vld |-> $past(dv) && $past(state) == PS_BODY);              // R2
    AST_EVENT_ONLY: assert property (@(posedge clk) disable iff (rst)
        stamp_vld |-> !stamp.msg_type[3]);                               // R5
    AST_ACT_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        stamp_vld |=> !stamp_vld);                                       // R12

endmodule

// File: rtl/ptp_stamp_slot.sv
module ptp_stamp_slot
    import ptp_tsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_vld,
    input  ptp_stamp_t wr_stamp,
    input  logic       release_i,
    output logic       full,
    output logic       ovf,
    output ptp_stamp_t held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            ovf  <= 1'b0;
            held <= '0;
        end else begin
            if (wr_vld) begin
                held <= wr_stamp;
                full <= 1'b1;
                if (full && !release_i) ovf <= 1'b1;
                else if (release_i)     ovf <= 1'b0;
            end else if (release_i) begin
                full <= 1'b0;
                ovf  <= 1'b0;
            end
        end
    end

    AST_NO_OVF_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        ovf |-> full);                                                   // R10
    AST_FULL_FROM_STAMP: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(wr_vld));                                  // R11
    AST_RELEASE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        release_i && !wr_vld |=> !full);                                 // R9

endmodule

// File: rtl/ptp_mii_tsu.sv
module ptp_mii_tsu
    import ptp_tsu_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int TRIM_W  = 4,
    parameter int NS_STEP = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_dv,
    input  logic [3:0]        rx_d,
    input  logic              tx_en,
    input  logic [3:0]        tx_d,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq,
    output logic              rx_act,
    output logic              tx_act
);

    localparam int NDIR       = 2;
    localparam int ADR_STATUS = 0;
    localparam int ADR_SEC    = 1;
    localparam int ADR_NS     = 2;
    localparam int ADR_TRIM   = 3;
    localparam int ADR_SLOT0  = 8;
    localparam int SLOT_STRIDE = 4;
    localparam int INFO_OFS   = 2;

    logic [NDIR-1:0]        dv_a;
    logic [3:0]             nib_a [NDIR];
    logic [NDIR-1:0]        commit;
    ptp_stamp_t             cstamp [NDIR];
    logic [NDIR-1:0]        full, ovf, rel_slot;
    ptp_stamp_t             held [NDIR];

    ptp_time_t                now, load_val;
    logic                     load;
    logic [SEC_W-1:0]         sec_stage;
    logic signed [TRIM_W-1:0] trim;
    logic                     trim_ok;
    logic [DATA_W-1:0]        rd_mux;

    assign dv_a[0]  = rx_dv;
    assign dv_a[1]  = tx_en;
    assign nib_a[0] = rx_d;
    assign nib_a[1] = tx_d;

    assign load = host_wr && host_addr == ADDR_W'(ADR_NS);
    assign load_val.sec = sec_stage;
    assign load_val.ns  = (host_wdata >= DATA_W'(NS_PER_SEC)) ? '0 : host_wdata[NS_W-1:0];

    assign trim_ok = (host_wdata[DATA_W-1:TRIM_W-1] == '0) ||
                     (host_wdata[DATA_W-1:TRIM_W-1] == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_stage <= '0;
            trim      <= '0;
        end else if (host_wr) begin
            if (host_addr == ADDR_W'(ADR_SEC)) sec_stage <= host_wdata[SEC_W-1:0];
            if (host_addr == ADDR_W'(ADR_TRIM) && trim_ok) trim <= host_wdata[TRIM_W-1:0];
        end
    end

    ptp_time_base #(.TRIM_W(TRIM_W), .NS_STEP(NS_STEP)) u_time (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .trim(trim), .now(now)
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        assign rel_slot[d] = host_rd &&
            host_addr == ADDR_W'(ADR_SLOT0 + SLOT_STRIDE*d + INFO_OFS);

        mii_ptp_snoop u_snoop (
            .clk(clk), .rst(rst), .dv(dv_a[d]), .nib(nib_a[d]), .now(now),
            .stamp_vld(commit[d]), .stamp(cstamp[d])
        );

        ptp_stamp_slot u_slot (
            .clk(clk), .rst(rst), .wr_vld(commit[d]), .wr_stamp(cstamp[d]),
            .release_i(rel_slot[d]), .full(full[d]), .ovf(ovf[d]), .held(held[d])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (host_addr >= ADDR_W'(ADR_SLOT0)) begin
            unique case (host_addr[1:0])
                2'd0: rd_mux = DATA_W'(held[host_addr[2]].ts.sec);
                2'd1: rd_mux = DATA_W'(held[host_addr[2]].ts.ns);
                2'd2: rd_mux = DATA_W'({held[host_addr[2]].msg_type,
                                        held[host_addr[2]].seq_id});
                default: rd_mux = '0;
            endcase
        end else begin
            case (host_addr)
                ADDR_W'(ADR_STATUS): rd_mux = DATA_W'({ovf[1], full[1], ovf[0], full[0]});
                ADDR_W'(ADR_SEC):    rd_mux = DATA_W'(sec_stage);
                ADDR_W'(ADR_TRIM):   rd_mux = {{(DATA_W-TRIM_W){trim[TRIM_W-1]}}, trim};
                default:             rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    assign irq    = |full;
    assign rx_act = commit[0];
    assign tx_act = commit[1];

    AST_IRQ_NEEDS_SLOT: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(commit != '0));                             // R11
    AST_TRIM_RANGE_KEPT: assert property (@(posedge clk) disable iff (rst)
        host_wr && host_addr == ADDR_W'(ADR_TRIM) && !trim_ok |=> $stable(trim)); // R8

endmodule

// File: tb/tb_ptp_mii_tsu.sv
module tb_ptp_mii_tsu;

    localparam longint NSEC = 1000000000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_dv = 1'b0, tx_en = 1'b0;
    logic [3:0]  rx_d = '0, tx_d = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq, rx_act, tx_act;

    always #4 clk = ~clk;

    ptp_mii_tsu dut (
        .clk(clk), .rst(rst), .rx_dv(rx_dv), .rx_d(rx_d), .tx_en(tx_en), .tx_d(tx_d),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .rx_act(rx_act), .tx_act(tx_act)
    );

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    int act_cnt [2] = '{0, 0};
    int good_cnt [2] = '{0, 0};
    bit done = 0;

    always @(negedge clk) begin
        if (rx_act) act_cnt[0]++;
        if (tx_act) act_cnt[1]++;
    end

    longint ld_sec = 0, ld_ns = 0, step = 20;
    int unsigned ld_cyc = 0;
    logic [7:0] frm [2][128];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic hwrite(input int a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 4'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input int a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = 4'(a);
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic set_time(input longint s, input longint n);
        hwrite(1, 32'(s));
        hwrite(2, 32'(n));
        ld_cyc = cyc;
        ld_sec = s; ld_ns = (n >= NSEC) ? 0 : n;
    endtask

    function automatic longint exp_sec(input int unsigned c);
        return (ld_sec + (ld_ns + longint'(c - ld_cyc) * step) / NSEC) & 64'hFFFF_FFFF;
    endfunction
    function automatic longint exp_ns(input int unsigned c);
        return (ld_ns + longint'(c - ld_cyc) * step) % NSEC;
    endfunction

    task automatic drive(input int d, input logic v, input logic [3:0] n);
        if (d == 0) begin rx_dv = v; rx_d = n; end
        else begin tx_en = v; tx_d = n; end
    endtask

    // kinds: 0 L2 ok, 1 L3 ok, 2 bad ethertype, 3 bad udp port,
    //        4 bad ip protocol, 5 general message, 6 truncated
    function automatic int build(input int d, input int kind,
                                 input logic [3:0] mt, input logic [15:0] seq);
        int base, len;
        for (int i = 0; i < 128; i++) frm[d][i] = 8'($urandom);
        base = (kind == 0 || kind == 2 || kind == 5) ? 14 : 42;
        if (base == 14) begin
            frm[d][12] = 8'h88; frm[d][13] = 8'hF7;
            if (kind == 2) frm[d][13] = 8'hF8;
        end else begin
            frm[d][12] = 8'h08; frm[d][13] = 8'h00; frm[d][14] = 8'h45;
            frm[d][23] = (kind == 4) ? 8'd6 : 8'd17;
            frm[d][36] = 8'h01; frm[d][37] = (kind == 3) ? 8'h40 : 8'h3F;
        end
        frm[d][base] = {frm[d][base][7:4], (kind == 5) ? 4'hB : mt};
        frm[d][base+30] = seq[15:8];
        frm[d][base+31] = seq[7:0];
        len = (kind == 6) ? base + 31 : base + 34 + 4'($urandom);
        return len;
    endfunction

    task automatic send(input int d, input int len, output int unsigned cfirst);
        int npre;
        npre = 1 + ($urandom % 15);
        for (int i = 0; i < npre; i++) begin @(negedge clk); drive(d, 1'b1, 4'h5); end
        @(negedge clk); drive(d, 1'b1, 4'hD);
        for (int i = 0; i < len; i++) begin
            @(negedge clk); drive(d, 1'b1, frm[d][i][3:0]);
            if (i == 0) cfirst = cyc;
            @(negedge clk); drive(d, 1'b1, frm[d][i][7:4]);
        end
        @(negedge clk); drive(d, 1'b0, 4'h0);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_slot(input int d, input int unsigned c, input logic [3:0] mt,
                              input logic [15:0] seq, input string req);
        logic [31:0] v;
        hread(8 + 4*d, v);
        check(v == 32'(exp_sec(c)), req, "stamp seconds", v, exp_sec(c));
        hread(9 + 4*d, v);
        check(v == 32'(exp_ns(c)), req, "stamp nanoseconds", v, exp_ns(c));
        hread(10 + 4*d, v);
        check(v == {12'h0, mt, seq}, req, "stamp info", v, {12'h0, mt, seq});
    endtask

    task automatic one_frame(input int d, input int kind);
        logic [3:0] mt; logic [15:0] seq; int len; int unsigned c;
        logic [31:0] st;
        bit good;
        mt = 4'($urandom % 4); seq = 16'($urandom);
        good = (kind <= 1);
        len = build(d, kind, mt, seq);
        send(d, len, c);
        hread(0, st);
        if (good) begin
            good_cnt[d]++;
            check(st == 32'(1 << (2*d)), "R3 R4 R10", "status after event frame",
                  st, 1 << (2*d));
            check_slot(d, c, mt, seq, kind == 0 ? "R1 R3 R5" : "R1 R4 R5");
            hread(0, st);
            check(st == 0, "R9", "status after info read", st, 0);
        end else begin
            check(st == 0, "R2 R5", "status after rejected frame", st, 0);
        end
    endtask

    initial begin
        logic [31:0] v;
        int unsigned c0, c1;
        void'($urandom(32'd20577));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        check(irq == 1'b0, "R11", "irq after reset", irq, 0);
        hread(0, v);
        check(v == 0, "R10", "status after reset", v, 0);
        hread(3, v);
        check(v == 0, "R8", "trim after reset", v, 0);

        // R7 load then R1/R3 stamp
        set_time(64'd1234, 64'd5000);
        one_frame(0, 0);
        one_frame(1, 1);

        // R6 rollover inside the stamp window
        set_time(64'd77, NSEC - 200);
        one_frame(0, 0);
        set_time(64'hFFFF_FFFF, NSEC - 100);
        one_frame(1, 0);

        // R7 out-of-range nanoseconds load as zero
        set_time(64'd9, NSEC + 5);
        one_frame(0, 1);

        // R8 negative trim, readback, and out-of-range write ignored
        hwrite(3, 32'hFFFF_FFFD);
        hread(3, v);
        check(v == 32'hFFFF_FFFD, "R8", "trim readback", v, 32'hFFFF_FFFD);
        hwrite(3, 32'd9);
        hread(3, v);
        check(v == 32'hFFFF_FFFD, "R8", "out-of-range trim ignored", v, 32'hFFFF_FFFD);
        step = 17;
        set_time(64'd500, 64'd100);
        one_frame(0, 0);
        one_frame(1, 1);

        // R2 R4 R5 each rejection reason
        for (int k = 2; k <= 6; k++) one_frame(k % 2, k);

        // R10 R11 overflow keeps the newer stamp
        begin
            logic [15:0] s1, s2; int l;
            s1 = 16'h1111; s2 = 16'h2222;
            l = build(0, 0, 4'h1, s1); send(0, l, c0);
            check(irq == 1'b1, "R11", "irq with full slot", irq, 1);
            l = build(0, 1, 4'h3, s2); send(0, l, c1);
            hread(0, v);
            check(v == 32'h3, "R10", "overflow status", v, 3);
            check_slot(0, c1, 4'h3, s2, "R10");
            hread(0, v);
            check(v == 0, "R10", "overflow cleared", v, 0);
            check(irq == 1'b0, "R11", "irq after release", irq, 0);
            good_cnt[0] += 2;
        end

        // R13 both sides at once
        begin
            int l0, l1;
            l0 = build(0, 0, 4'h2, 16'hA5A5);
            l1 = build(1, 1, 4'h0, 16'h5A5A);
            fork
                send(0, l0, c0);
                send(1, l1, c1);
            join
            hread(0, v);
            check(v == 32'h5, "R13", "both slots full", v, 5);
            check_slot(0, c0, 4'h2, 16'hA5A5, "R13");
            check_slot(1, c1, 4'h0, 16'h5A5A, "R13");
            good_cnt[0]++; good_cnt[1]++;
        end

        // random mix
        for (int i = 0; i < 40; i++) begin
            if (i % 10 == 0) begin
                logic signed [3:0] t;
                t = 4'($urandom);
                hwrite(3, {{28{t[3]}}, t});
                step = 20 + t;
                set_time(longint'($urandom), longint'($urandom % NSEC));
            end
            one_frame($urandom % 2, ($urandom % 3 == 0) ? 2 + $urandom % 5 : $urandom % 2);
        end

        check(act_cnt[0] == good_cnt[0], "R12", "rx activity pulses", act_cnt[0], good_cnt[0]);
        check(act_cnt[1] == good_cnt[1], "R12", "tx activity pulses", act_cnt[1], good_cnt[1]);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end

endmodule